// File: doc/BRIEF.md
# Virtual Interrupt End-of-Interrupt Status Word

This block produces a read-only 32-bit status word for a virtual interrupt interface. Each of the 16 low bits flags one virtual interrupt list entry whose end-of-interrupt maintenance event is still pending. A bit is raised when the entry is idle, is not linked to a physical interrupt, and asks for a maintenance event on deactivation. The list entries live elsewhere. This block only watches their fields and keeps a registered snapshot of the qualifier results.

The block also handles a system-register read of that word. It matches the instruction encoding and then walks a privilege decision tree. Depending on the current exception level, the hypervisor trap bit, the register-interface enables and the width of the hypervisor, the read returns data, raises undefined-instruction, or traps to the hypervisor on its 64-bit or 32-bit path with syndrome code 0x03.

The response is driven by a small state machine:
- ACC_IDLE: no response.
- ACC_READ, ACC_UNDEF, ACC_TRAP64, ACC_TRAP32: one-cycle response states.

Transitions:
- A matching request moves the machine from any state into the response state that the decision tree selects.
- With no matching request, every state returns to ACC_IDLE.

Top module: `veoi_status_top`

## Requirements
- R1: Status bit n is 1 exactly when entry n has state field 2'b00, hardware-link flag 0 and EOI-request flag 1. Entry n's state sits at bits [2n+1:2n] of `ent_state`.
- R2: Bits 31:16 of `rsp_data` are always zero.
- R3: While `rst_n` is low, every response output is 0 and the status snapshot is cleared. A read taken at the first edge after release returns the cleared snapshot.
- R4: The status snapshot follows the entry fields with one register stage. A read sampled at the same edge as a field change returns the value from before the change.
- R5: A request is recognised only for coprocessor 15, opc1=4, CRn=12, CRm=11, opc2=3. Any other encoding produces no response.
- R6: A read at exception level 0 (`cur_el`=0) raises undefined-instruction.
- R7: A read at level 1 traps to the hypervisor when level 2 is present, level 2 is enabled and `hyp_trap_crn12` is 1. The trap uses `rsp_trap64` when `el2_is_64` is 1 and `rsp_trap32` otherwise. `rsp_syndrome` is 0x03 during a trap and 0 otherwise.
- R8: A read at level 1 that does not trap raises undefined-instruction.
- R9: A read at level 2 returns the status word when `hyp_sysif_en` is 1. Otherwise it raises undefined-instruction.
- R10: A read at level 3 returns data when `mon_sysif_en` is 1 and raises undefined-instruction otherwise. The data is all zero when `el2_present` is 0.
- R11: A response appears in the cycle after the request edge and lasts one cycle. At most one of `rsp_valid`, `rsp_undef`, `rsp_trap64`, `rsp_trap32` is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous warm reset |
| ent_state | input | 32 | Two-bit state field per entry |
| ent_hwlink | input | 16 | Hardware-link flag per entry |
| ent_eoi_req | input | 16 | EOI-request flag per entry |
| req_valid | input | 1 | Read request strobe |
| req_coproc | input | 4 | Coprocessor number |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_opc2 | input | 3 | Second opcode field |
| cur_el | input | 2 | Current exception level |
| el2_present | input | 1 | Level 2 is implemented |
| el2_enabled | input | 1 | Level 2 is enabled for the current context |
| el2_is_64 | input | 1 | Level 2 runs with 64-bit registers |
| hyp_trap_crn12 | input | 1 | Hypervisor trap enable for CRn=12 accesses |
| hyp_sysif_en | input | 1 | Register interface enable at level 2 |
| mon_sysif_en | input | 1 | Register interface enable at level 3 |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| rsp_undef | output | 1 | Undefined-instruction indication |
| rsp_trap64 | output | 1 | Trap to a 64-bit hypervisor |
| rsp_trap32 | output | 1 | Trap to a 32-bit hypervisor |
| rsp_syndrome | output | 6 | Trap syndrome code |

## Verification
The bench builds the block with its default parameters: 16 entries, a 2-bit state field and a 32-bit word. At this size the whole input space is small enough to cover.

Every entry is driven through all 16 combinations of state, hardware-link and EOI-request, each against a changing background on the other entries. Every exception level is crossed with all 64 settings of the presence, enable, width, trap and interface-enable bits. On top of that, directed cases cover the reset snapshot, the one-stage status latency, the upper zero bits and every single-field mismatch of the encoding.

// File: rtl/veoi_pkg.sv
package veoi_pkg;
    typedef enum logic [2:0] {
        ACC_IDLE   = 3'd0,
        ACC_READ   = 3'd1,
        ACC_UNDEF  = 3'd2,
        ACC_TRAP64 = 3'd3,
        ACC_TRAP32 = 3'd4
    } acc_state_e;

    typedef enum logic [1:0] {
        LVL_USER   = 2'd0,
        LVL_KERNEL = 2'd1,
        LVL_HYP    = 2'd2,
        LVL_MON    = 2'd3
    } exc_level_e;

    localparam int SYND_W = 6;
    localparam logic [SYND_W-1:0] TRAP_SYNDROME = 6'h03;
endpackage

// File: rtl/veoi_status_gen.sv
module veoi_status_gen #(
    parameter int NUM_ENT = 16,
    parameter int STATE_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_ENT*STATE_W-1:0] ent_state,
    input  logic [NUM_ENT-1:0]         ent_hwlink,
    input  logic [NUM_ENT-1:0]         ent_eoi_req,
    output logic [NUM_ENT-1:0]         status_q
);
    logic [NUM_ENT-1:0] qual;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        assign qual[g] = (ent_state[g*STATE_W +: STATE_W] == '0)
                       & ~ent_hwlink[g] & ent_eoi_req[g];

        // a set bit needs an EOI request in the previous cycle
        assert_eoi_needed_R1: assert property (@(posedge clk) disable iff (!rst_n)
            status_q[g] |-> $past(ent_eoi_req[g]));
        // a hardware-linked entry never flags
        assert_hw_excludes_R1: assert property (@(posedge clk) disable iff (!rst_n)
            status_q[g] |-> !$past(ent_hwlink[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= qual;
    end
endmodule

// File: rtl/veoi_enc_match.sv
module veoi_enc_match #(
    parameter logic [3:0] COPROC = 4'd15,
    parameter logic [2:0] OPC1   = 3'd4,
    parameter logic [3:0] CRN    = 4'd12,
    parameter logic [3:0] CRM    = 4'd11,
    parameter logic [2:0] OPC2   = 3'd3
) (
    input  logic       req_valid,
    input  logic [3:0] req_coproc,
    input  logic [2:0] req_opc1,
    input  logic [3:0] req_crn,
    input  logic [3:0] req_crm,
    input  logic [2:0] req_opc2,
    output logic       req_hit
);
    always_comb begin
        req_hit = req_valid
                & (req_coproc == COPROC)
                & (req_opc1 == OPC1)
                & (req_crn == CRN)
                & (req_crm == CRM)
                & (req_opc2 == OPC2);
    end
endmodule

// File: rtl/veoi_access_ctrl.sv
module veoi_access_ctrl
    import veoi_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_hit,
    input  logic [1:0]         cur_el,
    input  logic               el2_present,
    input  logic               el2_enabled,
    input  logic               el2_is_64,
    input  logic               hyp_trap_crn12,
    input  logic               hyp_sysif_en,
    input  logic               mon_sysif_en,
    input  logic [NUM_ENT-1:0] status_word,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               rsp_undef,
    output logic               rsp_trap64,
    output logic               rsp_trap32,
    output logic [SYND_W-1:0]  rsp_syndrome
);
    localparam int PAD_W = DATA_W - NUM_ENT;

    acc_state_e state_q, state_d;
    logic [NUM_ENT-1:0] snap_q;
    logic               l2_live;

    assign l2_live = el2_present & el2_enabled;

    // next-state decision tree
    always_comb begin
        state_d = ACC_IDLE;
        if (req_hit) begin
            unique case (exc_level_e'(cur_el))
                LVL_USER:   state_d = ACC_UNDEF;
                LVL_KERNEL: begin
                    if (l2_live && hyp_trap_crn12)
                        state_d = el2_is_64 ? ACC_TRAP64 : ACC_TRAP32;
                    else
                        state_d = ACC_UNDEF;
                end
                LVL_HYP:    state_d = hyp_sysif_en ? ACC_READ : ACC_UNDEF;
                LVL_MON:    state_d = mon_sysif_en ? ACC_READ : ACC_UNDEF;
                default:    state_d = ACC_UNDEF;
            endcase
        end
    end

    // state register and data snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_hit)
                snap_q <= (cur_el == LVL_MON && !el2_present) ? '0 : status_word;
        end
    end

    // outputs from state
    always_comb begin
        rsp_valid    = 1'b0;
        rsp_undef    = 1'b0;
        rsp_trap64   = 1'b0;
        rsp_trap32   = 1'b0;
        rsp_syndrome = '0;
        rsp_data     = '0;
        unique case (state_q)
            ACC_IDLE:   ;
            ACC_READ: begin
                rsp_valid = 1'b1;
                rsp_data  = {{PAD_W{1'b0}}, snap_q};
            end
            ACC_UNDEF:  rsp_undef = 1'b1;
            ACC_TRAP64: begin
                rsp_trap64   = 1'b1;
                rsp_syndrome = TRAP_SYNDROME;
            end
            ACC_TRAP32: begin
                rsp_trap32   = 1'b1;
                rsp_syndrome = TRAP_SYNDROME;
            end
            default:    ;
        endcase
    end

    assert_el0_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && cur_el == 2'd0) |=> rsp_undef);
    assert_hyp_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && cur_el == 2'd2 && !hyp_sysif_en) |=> (rsp_undef && !rsp_valid));
    assert_trap_syndrome_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap64 || rsp_trap32) |-> (rsp_syndrome == 6'h03));
    assert_one_response_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, rsp_undef, rsp_trap64, rsp_trap32}));
    assert_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_hit |=> !(rsp_valid || rsp_undef || rsp_trap64 || rsp_trap32));
endmodule

// File: rtl/veoi_status_top.sv
module veoi_status_top
    import veoi_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int STATE_W = 2,
    parameter int DATA_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_ENT*STATE_W-1:0] ent_state,
    input  logic [NUM_ENT-1:0]         ent_hwlink,
    input  logic [NUM_ENT-1:0]         ent_eoi_req,
    input  logic                       req_valid,
    input  logic [3:0]                 req_coproc,
    input  logic [2:0]                 req_opc1,
    input  logic [3:0]                 req_crn,
    input  logic [3:0]                 req_crm,
    input  logic [2:0]                 req_opc2,
    input  logic [1:0]                 cur_el,
    input  logic                       el2_present,
    input  logic                       el2_enabled,
    input  logic                       el2_is_64,
    input  logic                       hyp_trap_crn12,
    input  logic                       hyp_sysif_en,
    input  logic                       mon_sysif_en,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_data,
    output logic                       rsp_undef,
    output logic                       rsp_trap64,
    output logic                       rsp_trap32,
    output logic [SYND_W-1:0]          rsp_syndrome
);
    logic [NUM_ENT-1:0] status_q;
    logic               req_hit;

    veoi_status_gen #(.NUM_ENT(NUM_ENT), .STATE_W(STATE_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ent_state  (ent_state),
        .ent_hwlink (ent_hwlink),
        .ent_eoi_req(ent_eoi_req),
        .status_q   (status_q)
    );

    veoi_enc_match u_match (
        .req_valid (req_valid),
        .req_coproc(req_coproc),
        .req_opc1  (req_opc1),
        .req_crn   (req_crn),
        .req_crm   (req_crm),
        .req_opc2  (req_opc2),
        .req_hit   (req_hit)
    );

    veoi_access_ctrl #(.NUM_ENT(NUM_ENT), .DATA_W(DATA_W)) u_access (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_hit       (req_hit),
        .cur_el        (cur_el),
        .el2_present   (el2_present),
        .el2_enabled   (el2_enabled),
        .el2_is_64     (el2_is_64),
        .hyp_trap_crn12(hyp_trap_crn12),
        .hyp_sysif_en  (hyp_sysif_en),
        .mon_sysif_en  (mon_sysif_en),
        .status_word   (status_q),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data),
        .rsp_undef     (rsp_undef),
        .rsp_trap64    (rsp_trap64),
        .rsp_trap32    (rsp_trap32),
        .rsp_syndrome  (rsp_syndrome)
    );

    assert_foreign_coproc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_coproc != 4'd15)
        |=> !(rsp_valid || rsp_undef || rsp_trap64 || rsp_trap32));
endmodule

// File: tb/veoi_status_top_tb_top.sv
module veoi_status_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ent_state = '0;
    logic [15:0] ent_hwlink = '0;
    logic [15:0] ent_eoi_req = '0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_coproc = 4'd15;
    logic [2:0]  req_opc1 = 3'd4;
    logic [3:0]  req_crn = 4'd12;
    logic [3:0]  req_crm = 4'd11;
    logic [2:0]  req_opc2 = 3'd3;
    logic [1:0]  cur_el = 2'd2;
    logic        el2_present = 1'b1;
    logic        el2_enabled = 1'b1;
    logic        el2_is_64 = 1'b1;
    logic        hyp_trap_crn12 = 1'b0;
    logic        hyp_sysif_en = 1'b1;
    logic        mon_sysif_en = 1'b1;
    logic        rsp_valid, rsp_undef, rsp_trap64, rsp_trap32;
    logic [31:0] rsp_data;
    logic [5:0]  rsp_syndrome;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    veoi_status_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .ent_state(ent_state), .ent_hwlink(ent_hwlink), .ent_eoi_req(ent_eoi_req),
        .req_valid(req_valid), .req_coproc(req_coproc), .req_opc1(req_opc1),
        .req_crn(req_crn), .req_crm(req_crm), .req_opc2(req_opc2),
        .cur_el(cur_el), .el2_present(el2_present), .el2_enabled(el2_enabled),
        .el2_is_64(el2_is_64), .hyp_trap_crn12(hyp_trap_crn12),
        .hyp_sysif_en(hyp_sysif_en), .mon_sysif_en(mon_sysif_en),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_undef(rsp_undef),
        .rsp_trap64(rsp_trap64), .rsp_trap32(rsp_trap32), .rsp_syndrome(rsp_syndrome)
    );

    // response codes: 0 none, 1 read, 2 undef, 3 trap64, 4 trap32, 9 several
    // vector: {el[1:0], present, enabled, is64, trap, hyp_en, mon_en, code[2:0]}
    localparam logic [10:0] ACC_VEC [12] = '{
        11'b00_1_1_1_1_1_1_010,
        11'b01_1_1_1_1_0_0_011,
        11'b01_1_1_0_1_0_0_100,
        11'b01_1_1_1_0_1_1_010,
        11'b01_1_0_1_1_0_0_010,
        11'b01_0_1_1_1_0_0_010,
        11'b10_1_1_0_0_1_0_001,
        11'b10_1_1_0_1_0_1_010,
        11'b11_1_1_0_0_0_1_001,
        11'b11_1_1_0_0_1_0_010,
        11'b11_0_0_0_0_0_1_001,
        11'b10_1_1_1_1_1_0_001
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int resp_code();
        int n;
        n = int'(rsp_valid) + int'(rsp_undef) + int'(rsp_trap64) + int'(rsp_trap32);
        if (n == 0) return 0;
        if (n > 1) return 9;
        if (rsp_valid) return 1;
        if (rsp_undef) return 2;
        if (rsp_trap64) return 3;
        return 4;
    endfunction

    function automatic int ref_code(logic [1:0] el, logic p, logic en, logic w64,
                                    logic tr, logic he, logic me);
        case (el)
            2'd0: return 2;
            2'd1: return (p && en && tr) ? (w64 ? 3 : 4) : 2;
            2'd2: return he ? 1 : 2;
            default: return me ? 1 : 2;
        endcase
    endfunction

    function automatic logic ref_qual(logic [1:0] st, logic hw, logic eo);
        return (st == 2'b00) && !hw && eo;
    endfunction

    // issue one request at a negedge, sample the response at the next negedge
    task automatic issue(output int code, output logic [31:0] data, output logic [5:0] syn);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        code = resp_code();
        data = rsp_data;
        syn  = rsp_syndrome;
    endtask

    task automatic set_ctrl(input logic [1:0] el, input logic p, input logic en,
                            input logic w64, input logic tr, input logic he, input logic me);
        cur_el = el; el2_present = p; el2_enabled = en; el2_is_64 = w64;
        hyp_trap_crn12 = tr; hyp_sysif_en = he; mon_sysif_en = me;
    endtask

    task automatic load_pattern(input logic [15:0] pat);
        ent_state = '0;
        ent_hwlink = '0;
        ent_eoi_req = pat;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int code;
        logic [31:0] data;
        logic [5:0] syn;
        logic [15:0] exp_stat;

        // R3: outputs quiet during reset even with a matching request
        load_pattern(16'hFFFF);
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 reset quiet", {28'd0, rsp_valid, rsp_undef, rsp_trap64, rsp_trap32}, 32'd0);
        // R3: release with request pending; first edge captures the cleared snapshot
        rst_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 first read code", resp_code(), 1);
        chk("R3 first read data", rsp_data, 32'd0);
        @(negedge clk);
        chk("R11 one-cycle response", resp_code(), 0);

        // R2: all entries flagged, upper half still zero
        issue(code, data, syn);
        chk("R2 upper zero / full word", data, 32'h0000FFFF);

        // R4: fields change at the same edge as the request
        @(negedge clk);
        load_pattern(16'h1234);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 old snapshot", rsp_data, 32'h0000FFFF);
        issue(code, data, syn);
        chk("R4 new snapshot", data, 32'h00001234);

        // table of access vectors
        load_pattern(16'hA5C3);
        for (int i = 0; i < 12; i++) begin
            logic [10:0] v;
            v = ACC_VEC[i];
            set_ctrl(v[10:9], v[8], v[7], v[6], v[5], v[4], v[3]);
            issue(code, data, syn);
            chk("R6-R10 table code", code, {29'd0, v[2:0]});
            if (v[2:0] == 3'd1)
                chk("R10 table data", data, (v[10:9] == 2'd3 && !v[8]) ? 32'd0 : 32'h0000A5C3);
            chk("R7 table syndrome", {26'd0, syn}, (v[2:0] >= 3'd3) ? 32'd3 : 32'd0);
        end

        // exhaustive privilege sweep
        for (int el = 0; el < 4; el++) begin
            for (int b = 0; b < 64; b++) begin
                int e;
                logic [5:0] bb;
                bb = b[5:0];
                set_ctrl(el[1:0], bb[5], bb[4], bb[3], bb[2], bb[1], bb[0]);
                e = ref_code(el[1:0], bb[5], bb[4], bb[3], bb[2], bb[1], bb[0]);
                issue(code, data, syn);
                if (el == 0) chk("R6 sweep", code, e);
                else if (el == 1) chk("R7 R8 sweep", code, e);
                else if (el == 2) chk("R9 sweep", code, e);
                else chk("R10 sweep", code, e);
                if (e == 1)
                    chk("R10 sweep data", data, (el == 3 && !bb[5]) ? 32'd0 : 32'h0000A5C3);
                chk("R7 sweep syndrome", {26'd0, syn}, (e >= 3) ? 32'd3 : 32'd0);
            end
        end

        // R1: every field combination on every entry, with a varying background
        set_ctrl(2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        for (int n = 0; n < 16; n++) begin
            for (int c = 0; c < 16; c++) begin
                exp_stat = '0;
                for (int m = 0; m < 16; m++) begin
                    int k;
                    logic [3:0] kk;
                    k = (m == n) ? c : ((m * 5 + c + n) % 16);
                    kk = k[3:0];
                    ent_state[2*m +: 2] = kk[1:0];
                    ent_hwlink[m] = kk[2];
                    ent_eoi_req[m] = kk[3];
                    exp_stat[m] = ref_qual(kk[1:0], kk[2], kk[3]);
                end
                issue(code, data, syn);
                chk("R1 status word", data, {16'd0, exp_stat});
            end
        end

        // R5: one field off at a time gives no response
        load_pattern(16'hFFFF);
        for (int f = 0; f < 5; f++) begin
            req_coproc = (f == 0) ? 4'd14 : 4'd15;
            req_opc1   = (f == 1) ? 3'd0  : 3'd4;
            req_crn    = (f == 2) ? 4'd9  : 4'd12;
            req_crm    = (f == 3) ? 4'd10 : 4'd11;
            req_opc2   = (f == 4) ? 3'd2  : 3'd3;
            issue(code, data, syn);
            chk("R5 encoding mismatch", code, 0);
        end
        req_coproc = 4'd15; req_opc1 = 3'd4; req_crn = 4'd12; req_crm = 4'd11; req_opc2 = 3'd3;
        issue(code, data, syn);
        chk("R5 encoding restored", code, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule